// File: doc/BRIEF.md
# Ethernet DMA Control and Status Register Bank

This block is the software-visible register bank of a descriptor-driven Ethernet DMA engine. A host reaches it over a 32-bit register bus indexed by word (byte offset shifted right by two), with a write strobe and a read strobe. The bank holds the bus configuration word, the two descriptor ring base addresses, the two current descriptor pointers, the operating control word, the event status word and the interrupt mask. It drives a single level-sensitive interrupt request.

The transmit and receive engines report completions and descriptor shortages as single-cycle pulses. Each pulse sets its own status bit together with a summary bit. Software acknowledges an event by writing a one to its status bit. Programming a ring base also rewinds the matching engine pointer to that address. The engines move their pointers forward through dedicated update ports. A write to the transmit kick register stores nothing and sends a one-cycle start pulse to the transmit engine.

Read data is registered. It appears on `csr_rdata` in the cycle after the read strobe is sampled.

Register word indices: 0 bus configuration, 1 transmit kick, 2 receive ring base, 3 transmit ring base, 4 status, 5 control, 6 interrupt mask, 7 current receive pointer, 8 current transmit pointer, 9 version, 10 feature word.

Top module: `dma_csr_bank`

## Requirements
- R1: After reset every stored register reads zero, `irq` is low, and `rx_enable`, `tx_start` and `tx_poll_pulse` are low.
- R2: A write to status (index 4) clears each bit that is 1 in the written data. All other status bits are left unchanged.
- R3: An engine pulse sets its status bit. Transmit done sets bits 0 and 16. Transmit buffer unavailable sets bits 2 and 15. Receive done sets bits 6 and 16. Receive buffer unavailable sets bits 7 and 15.
- R4: If a software clear and an engine pulse target the same status bit in the same cycle, the bit ends set.
- R5: `irq` is high exactly when status AND interrupt mask (index 6) is nonzero. It follows each register write and each engine pulse in the next cycle.
- R6: A write to the receive ring base (index 2) also loads the current receive pointer (index 7) with the same value. The transmit ring base (index 3) behaves the same way for the transmit pointer (index 8).
- R7: A pointer update pulse from an engine loads that engine's current pointer and leaves the base unchanged. If software writes the base in the same cycle, the software value is kept.
- R8: Bit 0 of data written to bus configuration (index 0) is dropped, so that bit always reads 0.
- R9: The version register (index 9) always reads 0x1012, even after it is written.
- R10: A write to the transmit kick register (index 1) gives exactly one cycle of `tx_poll_pulse` and stores nothing: the register reads 0.
- R11: `rx_enable` follows control (index 5) bit 1, and `tx_start` follows control bit 13.
- R12: A read from an index above 10 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | AW | Register word index |
| csr_wr | input | 1 | Write strobe |
| csr_rd | input | 1 | Read strobe |
| csr_wdata | input | DW | Write data |
| csr_rdata | output | DW | Registered read data |
| tx_done_evt | input | 1 | Transmit frame completed pulse |
| tx_nobuf_evt | input | 1 | Transmit descriptor unavailable pulse |
| rx_done_evt | input | 1 | Receive frame completed pulse |
| rx_nobuf_evt | input | 1 | Receive descriptor unavailable pulse |
| rx_ptr_upd | input | 1 | Receive engine pointer load strobe |
| rx_ptr_next | input | DW | Next receive descriptor pointer |
| tx_ptr_upd | input | 1 | Transmit engine pointer load strobe |
| tx_ptr_next | input | DW | Next transmit descriptor pointer |
| irq | output | 1 | Level interrupt request |
| rx_enable | output | 1 | Receive engine enable |
| tx_start | output | 1 | Transmit engine run |
| tx_poll_pulse | output | 1 | One-cycle transmit kick |
| bus_mode | output | DW | Bus configuration word |
| rx_ring_base | output | DW | Receive ring base |
| tx_ring_base | output | DW | Transmit ring base |
| rx_desc_ptr | output | DW | Current receive descriptor pointer |
| tx_desc_ptr | output | DW | Current transmit descriptor pointer |

## Verification
The assertions assume that each engine event and pointer strobe lasts one cycle and is synchronous to `clk`. They also assume that read and write strobes are never asserted at the same time. The stimulus drives every input on the falling edge and holds each pulse for exactly one clock. Reads and writes are kept in separate cycles. The only deliberate overlaps are a status clear that coincides with an engine pulse, and a base write that coincides with a pointer update. These are the two races whose outcome the requirements fix.

// File: rtl/dma_csr_bank.sv
module dma_csr_bank #(
  parameter int          AW         = 10,
  parameter int          DW         = 32,
  parameter logic [31:0] VERSION_ID = 32'h0000_1012,
  parameter logic [31:0] FEATURES   = 32'h0000_0D05
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] csr_addr,
  input  logic          csr_wr,
  input  logic          csr_rd,
  input  logic [DW-1:0] csr_wdata,
  output logic [DW-1:0] csr_rdata,
  input  logic          tx_done_evt,
  input  logic          tx_nobuf_evt,
  input  logic          rx_done_evt,
  input  logic          rx_nobuf_evt,
  input  logic          rx_ptr_upd,
  input  logic [DW-1:0] rx_ptr_next,
  input  logic          tx_ptr_upd,
  input  logic [DW-1:0] tx_ptr_next,
  output logic          irq,
  output logic          rx_enable,
  output logic          tx_start,
  output logic          tx_poll_pulse,
  output logic [DW-1:0] bus_mode,
  output logic [DW-1:0] rx_ring_base,
  output logic [DW-1:0] tx_ring_base,
  output logic [DW-1:0] rx_desc_ptr,
  output logic [DW-1:0] tx_desc_ptr
);

  localparam logic [AW-1:0] IX_BUS  = AW'(0);
  localparam logic [AW-1:0] IX_KICK = AW'(1);
  localparam logic [AW-1:0] IX_RXB  = AW'(2);
  localparam logic [AW-1:0] IX_TXB  = AW'(3);
  localparam logic [AW-1:0] IX_STAT = AW'(4);
  localparam logic [AW-1:0] IX_CTRL = AW'(5);
  localparam logic [AW-1:0] IX_MASK = AW'(6);
  localparam logic [AW-1:0] IX_RXP  = AW'(7);
  localparam logic [AW-1:0] IX_TXP  = AW'(8);
  localparam logic [AW-1:0] IX_VER  = AW'(9);
  localparam logic [AW-1:0] IX_FEAT = AW'(10);

  localparam int B_TXD = 0, B_TXU = 2, B_RXD = 6, B_RXU = 7, B_ABN = 15, B_NRM = 16;
  localparam int B_RXEN = 1, B_TXGO = 13;

  logic [DW-1:0] status_q, mask_q, ctrl_q, set_vec, clr_vec;

  wire wr_bus  = csr_wr && csr_addr == IX_BUS;
  wire wr_kick = csr_wr && csr_addr == IX_KICK;
  wire wr_rxb  = csr_wr && csr_addr == IX_RXB;
  wire wr_txb  = csr_wr && csr_addr == IX_TXB;
  wire wr_stat = csr_wr && csr_addr == IX_STAT;
  wire wr_ctrl = csr_wr && csr_addr == IX_CTRL;
  wire wr_mask = csr_wr && csr_addr == IX_MASK;

  always_comb begin
    set_vec = '0;
    set_vec[B_TXD] = tx_done_evt;
    set_vec[B_TXU] = tx_nobuf_evt;
    set_vec[B_RXD] = rx_done_evt;
    set_vec[B_RXU] = rx_nobuf_evt;
    set_vec[B_NRM] = tx_done_evt | rx_done_evt;
    set_vec[B_ABN] = tx_nobuf_evt | rx_nobuf_evt;
  end

  assign clr_vec = wr_stat ? csr_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q      <= '0;
      mask_q        <= '0;
      ctrl_q        <= '0;
      bus_mode      <= '0;
      rx_ring_base  <= '0;
      tx_ring_base  <= '0;
      rx_desc_ptr   <= '0;
      tx_desc_ptr   <= '0;
      tx_poll_pulse <= 1'b0;
    end else begin
      status_q      <= (status_q & ~clr_vec) | set_vec;
      tx_poll_pulse <= wr_kick;
      if (wr_mask) mask_q <= csr_wdata;
      if (wr_ctrl) ctrl_q <= csr_wdata;
      if (wr_bus)  bus_mode <= {csr_wdata[DW-1:1], 1'b0};
      if (wr_rxb) begin
        rx_ring_base <= csr_wdata;
        rx_desc_ptr  <= csr_wdata;
      end else if (rx_ptr_upd) begin
        rx_desc_ptr  <= rx_ptr_next;
      end
      if (wr_txb) begin
        tx_ring_base <= csr_wdata;
        tx_desc_ptr  <= csr_wdata;
      end else if (tx_ptr_upd) begin
        tx_desc_ptr  <= tx_ptr_next;
      end
    end
  end

  assign irq       = |(status_q & mask_q);
  assign rx_enable = ctrl_q[B_RXEN];
  assign tx_start  = ctrl_q[B_TXGO];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_rdata <= '0;
    end else if (csr_rd) begin
      case (csr_addr)
        IX_BUS:  csr_rdata <= bus_mode;
        IX_RXB:  csr_rdata <= rx_ring_base;
        IX_TXB:  csr_rdata <= tx_ring_base;
        IX_STAT: csr_rdata <= status_q;
        IX_CTRL: csr_rdata <= ctrl_q;
        IX_MASK: csr_rdata <= mask_q;
        IX_RXP:  csr_rdata <= rx_desc_ptr;
        IX_TXP:  csr_rdata <= tx_desc_ptr;
        IX_VER:  csr_rdata <= DW'(VERSION_ID);
        IX_FEAT: csr_rdata <= DW'(FEATURES);
        default: csr_rdata <= '0;
      endcase
    end
  end

  a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && set_vec == '0) |=> status_q == ($past(status_q) & ~$past(csr_wdata)));

  a_r3_tx_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_evt |=> (status_q[B_TXD] && status_q[B_NRM]));

  a_r4_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_nobuf_evt && wr_stat) |=> (status_q[B_RXU] && status_q[B_ABN]));

  a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(csr_wr || (set_vec != '0)));

  a_r6_rx_base_loads_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rxb |=> rx_desc_ptr == $past(csr_wdata));

  a_r7_upd_keeps_base: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ptr_upd && !wr_txb) |=> (tx_desc_ptr == $past(tx_ptr_next) && $stable(tx_ring_base)));

  a_r9_version_const: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && csr_addr == IX_VER) |=> csr_rdata == DW'(VERSION_ID));

  a_r10_kick_source: assert property (@(posedge clk) disable iff (!rst_n)
    tx_poll_pulse |-> $past(wr_kick));

endmodule

// File: tb/dma_csr_bank_test.sv
module dma_csr_bank_test;
  localparam int AW = 10, DW = 32;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] csr_addr = '0;
  logic csr_wr = 0, csr_rd = 0;
  logic [DW-1:0] csr_wdata = '0, csr_rdata;
  logic tx_done_evt = 0, tx_nobuf_evt = 0, rx_done_evt = 0, rx_nobuf_evt = 0;
  logic rx_ptr_upd = 0, tx_ptr_upd = 0;
  logic [DW-1:0] rx_ptr_next = '0, tx_ptr_next = '0;
  logic irq, rx_enable, tx_start, tx_poll_pulse;
  logic [DW-1:0] bus_mode, rx_ring_base, tx_ring_base, rx_desc_ptr, tx_desc_ptr;

  int checks = 0, fails = 0, kicks = 0;

  always #4 clk = ~clk;

  dma_csr_bank #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr(csr_wr), .csr_rd(csr_rd),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .tx_done_evt(tx_done_evt), .tx_nobuf_evt(tx_nobuf_evt),
    .rx_done_evt(rx_done_evt), .rx_nobuf_evt(rx_nobuf_evt),
    .rx_ptr_upd(rx_ptr_upd), .rx_ptr_next(rx_ptr_next),
    .tx_ptr_upd(tx_ptr_upd), .tx_ptr_next(tx_ptr_next),
    .irq(irq), .rx_enable(rx_enable), .tx_start(tx_start), .tx_poll_pulse(tx_poll_pulse),
    .bus_mode(bus_mode), .rx_ring_base(rx_ring_base), .tx_ring_base(tx_ring_base),
    .rx_desc_ptr(rx_desc_ptr), .tx_desc_ptr(tx_desc_ptr));

  always @(posedge clk) if (rst_n && tx_poll_pulse) kicks++;

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    @(negedge clk);
    csr_addr = AW'(a); csr_wdata = d; csr_wr = 1;
    @(negedge clk);
    csr_wr = 0;
  endtask

  task automatic rd(int a, output logic [DW-1:0] d);
    @(negedge clk);
    csr_addr = AW'(a); csr_rd = 1;
    @(negedge clk);
    csr_rd = 0;
    d = csr_rdata;
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: tx_done_evt = 1;
      1: tx_nobuf_evt = 1;
      2: rx_done_evt = 1;
      default: rx_nobuf_evt = 1;
    endcase
    @(negedge clk);
    {tx_done_evt, tx_nobuf_evt, rx_done_evt, rx_nobuf_evt} = '0;
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    rd(4, v);  check("R1 status", v, 0);
    rd(5, v);  check("R1 control", v, 0);
    rd(7, v);  check("R1 rx ptr", v, 0);
    check("R1 irq", DW'(irq), 0);
    check("R1 outputs", DW'({rx_enable, tx_start, tx_poll_pulse}), 0);
  endtask

  task automatic t_events_w1c;
    logic [DW-1:0] v;
    pulse(0); rd(4, v); check("R3 tx done", v, 32'h0001_0001);
    pulse(3); rd(4, v); check("R3 rx nobuf", v, 32'h0001_8081);
    pulse(1); pulse(2); rd(4, v); check("R3 all", v, 32'h0001_80C5);
    wr(4, 32'h0000_0001); rd(4, v); check("R2 single clear", v, 32'h0001_80C4);
    wr(4, 32'hFFFF_FFFF); rd(4, v); check("R2 clear all", v, 0);
  endtask

  task automatic t_race;
    logic [DW-1:0] v;
    wr(4, 32'hFFFF_FFFF);
    pulse(2);
    @(negedge clk);
    csr_addr = AW'(4); csr_wdata = 32'h0001_0040; csr_wr = 1; rx_done_evt = 1;
    @(negedge clk);
    csr_wr = 0; rx_done_evt = 0;
    rd(4, v); check("R4 set wins", v, 32'h0001_0040);
    wr(4, 32'hFFFF_FFFF);
  endtask

  task automatic t_irq;
    wr(6, 32'h0000_0040);
    pulse(0); check("R5 masked event", DW'(irq), 0);
    pulse(2); check("R5 enabled event", DW'(irq), 1);
    wr(4, 32'h0000_0040); check("R5 cleared", DW'(irq), 0);
    wr(6, 32'h0001_0000); check("R5 mask raise", DW'(irq), 1);
    wr(6, 0); check("R5 mask drop", DW'(irq), 0);
    wr(4, 32'hFFFF_FFFF);
  endtask

  task automatic t_pointers;
    logic [DW-1:0] v;
    wr(2, 32'h1000_0040); rd(7, v); check("R6 rx ptr load", v, 32'h1000_0040);
    wr(3, 32'h2000_0080); check("R6 tx ptr port", tx_desc_ptr, 32'h2000_0080);
    @(negedge clk); rx_ptr_upd = 1; rx_ptr_next = 32'h1000_0060;
    @(negedge clk); rx_ptr_upd = 0;
    rd(7, v); check("R7 engine ptr", v, 32'h1000_0060);
    rd(2, v); check("R7 base kept", v, 32'h1000_0040);
    @(negedge clk);
    csr_addr = AW'(3); csr_wdata = 32'h3000_0000; csr_wr = 1;
    tx_ptr_upd = 1; tx_ptr_next = 32'h4000_0000;
    @(negedge clk); csr_wr = 0; tx_ptr_upd = 0;
    rd(8, v); check("R7 software wins", v, 32'h3000_0000);
  endtask

  task automatic t_misc;
    logic [DW-1:0] v;
    int k0;
    wr(0, 32'hFFFF_FFFF); rd(0, v); check("R8 bit0 dropped", v, 32'hFFFF_FFFE);
    wr(9, 0); rd(9, v); check("R9 version", v, 32'h0000_1012);
    k0 = kicks;
    wr(1, 32'hFFFF_FFFF); @(negedge clk);
    check("R10 one pulse", DW'(kicks - k0), 1);
    rd(1, v); check("R10 reads zero", v, 0);
    wr(5, 32'h0000_2002); check("R11 both on", DW'({rx_enable, tx_start}), 3);
    wr(5, 32'h0000_2000); check("R11 rx off", DW'({rx_enable, tx_start}), 1);
    rd(11, v);  check("R12 above range", v, 0);
    rd(1023, v); check("R12 top index", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_events_w1c();
    t_race();
    t_irq();
    t_pointers();
    t_misc();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule